// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind the serial protocol engine of a byte-addressed nonvolatile memory model. It gathers the data bytes of one write transaction into a page-sized staging buffer. When the stop event closes the transaction, it copies those bytes into the memory array through a RAM write port. A timed busy window follows the stop. The protocol engine uses the busy flag to withhold acknowledges until the window ends.

An address load opens a transaction. The upper address bits pick a page and stay fixed. The lower bits set the starting offset, which advances by one for each data byte and wraps inside the page. A per-offset valid mask records which offsets were loaded, so a partial page changes only those locations. The commit scans all offsets in ascending order, one per clock. It drives a write for each masked offset. Busy drops only when the scan has finished and the programmable busy timer has expired. A high write-protect pin at the stop cancels the commit.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, busy and ram_we are low.
- R2: An accepted address load sets the page to addr_in[15:7] and the offset to addr_in[6:0]. It clears the valid mask and opens a transaction. Each byte accepted later is stored at the current offset, and the offset then advances by one.
- R3: The offset is 7 bits wide and wraps from 127 to 0. The page bits never change within a transaction.
- R4: When more than 128 bytes are sent, a later byte replaces the earlier byte at the same offset. Each offset is still committed only once, with the last value sent to it.
- R5: The commit writes exactly the offsets that received data, at {page, offset}, in ascending offset order. The write for offset k appears k cycles after busy rises.
- R6: An accepted stop that closes an open transaction with at least one byte and a low write-protect pin raises busy on the next clock edge.
- R7: Busy stays high for max(BUSY_CYC, 128) cycles. With the default BUSY_CYC of 200, this is 200 cycles.
- R8: While busy is high, address loads, bytes and stops have no effect. An address load sent during busy does not open a transaction.
- R9: When wp_pin is high at the stop, no RAM write occurs and busy stays low. The transaction closes.
- R10: A stop after an address load with no data bytes starts no commit and leaves busy low.
- R11: A byte that arrives while no transaction is open is ignored. A stop then starts no commit.
- R12: ram_we is high only while busy is high.
- R13: When strobes coincide in one cycle, the address load wins over the stop, and the stop wins over a data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_ld | input | 1 | Load-address strobe, opens a transaction |
| addr_in | input | 16 | Start address: page in [15:7], offset in [6:0] |
| byte_vld | input | 1 | Data-byte strobe |
| byte_in | input | 8 | Data byte |
| stop_evt | input | 1 | Stop strobe that closes the transaction |
| wp_pin | input | 1 | Write protect, high blocks the commit |
| busy | output | 1 | High during the commit and busy window |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | RAM write address {page, offset} |
| ram_wdata | output | 8 | RAM write data |

## Verification
Inputs are driven in the low half of the clock, and outputs are read at falling edges. A stop is captured at the next rising edge, so busy must be high at the falling edge that follows the stop strobe. Each write is then due exactly its offset number of cycles after that first busy cycle. The monitor keeps a position count that starts at zero on the first busy sample and compares each write against it. Busy is checked for exactly 200 high samples, less any cycles that the stimulus spent during the window. All expected addresses and data come from a page model in the bench.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  localparam int unsigned ADDR_W_DEF   = 16;
  localparam int unsigned OFS_W_DEF    = 7;
  localparam int unsigned DATA_W_DEF   = 8;
  localparam int unsigned BUSY_CYC_DEF = 200;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int unsigned ADDR_W = pgbuf_pkg::ADDR_W_DEF,
  parameter int unsigned OFS_W  = pgbuf_pkg::OFS_W_DEF,
  parameter int unsigned DATA_W = pgbuf_pkg::DATA_W_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     addr_ld,
  input  logic [ADDR_W-1:0]        addr_in,
  input  logic                     byte_vld,
  input  logic [DATA_W-1:0]        byte_in,
  input  logic                     txn_end,
  input  logic [OFS_W-1:0]         rd_idx,
  output logic                     open_o,
  output logic [ADDR_W-OFS_W-1:0]  page_o,
  output logic [(1<<OFS_W)-1:0]    mask_o,
  output logic [DATA_W-1:0]        rd_data
);
  localparam int unsigned DEPTH  = 1 << OFS_W;
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;

  logic              open_q, open_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic [DEPTH-1:0]  mask_q, mask_d;
  logic              wr_en;
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_comb begin
    open_d = open_q;
    page_d = page_q;
    ofs_d  = ofs_q;
    mask_d = mask_q;
    wr_en  = 1'b0;
    if (accept) begin
      if (addr_ld) begin
        open_d = 1'b1;
        page_d = addr_in[ADDR_W-1:OFS_W];
        ofs_d  = addr_in[OFS_W-1:0];
        mask_d = '0;
      end else if (txn_end) begin
        open_d = 1'b0;
      end else if (byte_vld && open_q) begin
        wr_en         = 1'b1;
        mask_d[ofs_q] = 1'b1;
        ofs_d         = ofs_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      page_q <= '0;
      ofs_q  <= '0;
      mask_q <= '0;
    end else begin
      open_q <= open_d;
      page_q <= page_d;
      ofs_q  <= ofs_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[ofs_q] <= byte_in;
  end

  assign open_o  = open_q;
  assign page_o  = page_q;
  assign mask_o  = mask_q;
  assign rd_data = mem_q[rd_idx];

  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && byte_vld && open_q && !addr_ld && !txn_end) |=> (page_q == $past(page_q)));

  // R11
  closed_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && byte_vld && !open_q && !addr_ld) |=> $stable(mask_q));

  // R8
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept) |=> ($stable(open_q) && $stable(mask_q) && $stable(ofs_q)));
endmodule

// File: rtl/pgbuf_walker.sv
module pgbuf_walker #(
  parameter int unsigned OFS_W    = pgbuf_pkg::OFS_W_DEF,
  parameter int unsigned BUSY_CYC = pgbuf_pkg::BUSY_CYC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cur_set,
  output logic             busy,
  output logic             walk_we,
  output logic [OFS_W-1:0] walk_idx
);
  import pgbuf_pkg::*;

  localparam int unsigned TMR_W = (BUSY_CYC < 2) ? 1 : $clog2(BUSY_CYC);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'((BUSY_CYC < 1) ? 0 : BUSY_CYC - 1);
  localparam logic [OFS_W-1:0] IDX_LAST = '1;

  walk_state_e      st_q, st_d;
  logic             on_q, on_d;
  logic [OFS_W-1:0] idx_q, idx_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_done, scan_done;

  assign tmr_done  = (tmr_q == TMR_LAST);
  assign scan_done = !on_q || (idx_q == IDX_LAST);

  always_comb begin
    st_d  = st_q;
    on_d  = on_q;
    idx_d = idx_q;
    tmr_d = tmr_q;
    unique case (st_q)
      WK_IDLE: begin
        if (start) begin
          st_d  = WK_RUN;
          on_d  = 1'b1;
          idx_d = '0;
          tmr_d = '0;
        end
      end
      WK_RUN: begin
        if (on_q) begin
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_LAST) on_d = 1'b0;
        end
        if (!tmr_done) tmr_d = tmr_q + 1'b1;
        if (tmr_done && scan_done) st_d = WK_IDLE;
      end
      default: st_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WK_IDLE;
      on_q  <= 1'b0;
      idx_q <= '0;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      on_q  <= on_d;
      idx_q <= idx_d;
      tmr_q <= tmr_d;
    end
  end

  assign busy     = (st_q == WK_RUN);
  assign walk_we  = on_q && cur_set;
  assign walk_idx = idx_q;

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R7
  min_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tmr_done) |=> busy);

  // R5
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_q && idx_q != IDX_LAST) |=> (on_q && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit #(
  parameter int unsigned ADDR_W   = pgbuf_pkg::ADDR_W_DEF,
  parameter int unsigned OFS_W    = pgbuf_pkg::OFS_W_DEF,
  parameter int unsigned DATA_W   = pgbuf_pkg::DATA_W_DEF,
  parameter int unsigned BUSY_CYC = pgbuf_pkg::BUSY_CYC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop_evt,
  input  logic              wp_pin,
  output logic              busy,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);
  localparam int unsigned DEPTH  = 1 << OFS_W;
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;

  logic [1:0]        rst_pipe_q;
  logic              rst_s_n;
  logic              accept, commit, open_w, walk_we;
  logic [PAGE_W-1:0] page_w;
  logic [DEPTH-1:0]  mask_w;
  logic [OFS_W-1:0]  walk_idx;
  logic [DATA_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  assign accept = !busy;
  assign commit = accept && stop_evt && !addr_ld && open_w && (|mask_w) && !wp_pin;

  pgbuf_store #(
    .ADDR_W (ADDR_W),
    .OFS_W  (OFS_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .accept   (accept),
    .addr_ld  (addr_ld),
    .addr_in  (addr_in),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .txn_end  (stop_evt),
    .rd_idx   (walk_idx),
    .open_o   (open_w),
    .page_o   (page_w),
    .mask_o   (mask_w),
    .rd_data  (rd_data)
  );

  pgbuf_walker #(
    .OFS_W    (OFS_W),
    .BUSY_CYC (BUSY_CYC)
  ) u_walk (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .start    (commit),
    .cur_set  (mask_w[walk_idx]),
    .busy     (busy),
    .walk_we  (walk_we),
    .walk_idx (walk_idx)
  );

  assign ram_we    = walk_we;
  assign ram_addr  = {page_w, walk_idx};
  assign ram_wdata = rd_data;

  // R12
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ram_we |-> busy);

  // R9
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy && stop_evt && wp_pin) |=> !busy);

  // R10
  empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!busy && stop_evt && mask_w == '0) |=> !busy);
endmodule

// File: tb/sim_pgbuf_commit.sv
`timescale 1ns/1ps
module sim_pgbuf_commit;
  localparam int BUSY     = 200;
  localparam int EXP_BUSY = (BUSY > 128) ? BUSY : 128;

  logic        clk, rst_n, addr_ld, byte_vld, stop_evt, wp_pin;
  logic [15:0] addr_in;
  logic [7:0]  byte_in;
  logic        busy, ram_we;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata;

  pgbuf_commit #(.BUSY_CYC(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_in(byte_in), .stop_evt(stop_evt),
    .wp_pin(wp_pin), .busy(busy), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct packed { logic [15:0] a; logic [7:0] d; } wr_t;
  wr_t exp_q[$];

  bit         m_open, m_busy;
  logic [8:0] m_page;
  logic [6:0] m_ofs;
  bit         m_mask [128];
  logic [7:0] m_data [128];
  int         walk_pos;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_ld(input logic [15:0] a);
    addr_ld = 1'b1; addr_in = a;
    if (!m_busy) begin
      m_open = 1; m_page = a[15:7]; m_ofs = a[6:0];
      for (int i = 0; i < 128; i++) m_mask[i] = 0;
    end
    @(negedge clk);
    addr_ld = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    byte_vld = 1'b1; byte_in = d;
    if (!m_busy && m_open) begin
      m_data[m_ofs] = d; m_mask[m_ofs] = 1; m_ofs = m_ofs + 1'b1;
    end
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic do_stop(input string tag);
    bit any, was_busy;
    was_busy = m_busy;
    stop_evt = 1'b1;
    if (!m_busy) begin
      any = 0;
      for (int i = 0; i < 128; i++) any |= m_mask[i];
      if (m_open && any && !wp_pin) begin
        for (int i = 0; i < 128; i++)
          if (m_mask[i]) exp_q.push_back({m_page, 7'(i), m_data[i]});
        m_busy = 1;
      end
      m_open = 0;
    end
    @(negedge clk);
    stop_evt = 1'b0;
    chk(busy == m_busy, {tag, " busy after stop"}, busy, m_busy);
    if (was_busy) walk_pos = walk_pos;
  endtask

  task automatic wait_idle(input int spent, input string tag);
    int n;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == EXP_BUSY - spent, {tag, " R7 busy length"}, n, EXP_BUSY - spent);
    chk(exp_q.size() == 0, {tag, " R5 writes pending"}, exp_q.size(), 0);
    m_busy = 0;
  endtask

  // monitor: compares RAM writes against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_we) begin
        chk(busy, "R12 write outside busy", busy, 1);
        if (exp_q.size() == 0) begin
          chk(0, "R5 unexpected write", ram_addr, 0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          chk(ram_addr == e.a && ram_wdata == e.d && int'(ram_addr[6:0]) == walk_pos,
              "R2 R3 R4 R5 write addr/data", {8'h0, ram_addr, ram_wdata}, {8'h0, e.a, e.d});
        end
      end
      if (busy) walk_pos++;
      else      walk_pos = 0;
    end else begin
      walk_pos = 0;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr_ld = 0; addr_in = '0; byte_vld = 0; byte_in = '0;
    stop_evt = 0; wp_pin = 0; m_open = 0; m_busy = 0; m_page = '0; m_ofs = '0;
    for (int i = 0; i < 128; i++) begin m_mask[i] = 0; m_data[i] = '0; end
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy in reset", busy, 0);
    chk(ram_we == 0, "R1 ram_we in reset", ram_we, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && ram_we == 0, "R1 idle after reset", {busy, ram_we}, 0);

    // single byte
    do_ld(16'h1234); do_byte(8'hA5); do_stop("R2 R6");
    wait_idle(0, "R2");

    // wrap across the page end
    do_ld({9'd5, 7'd125});
    for (int i = 0; i < 4; i++) do_byte(8'h40 + 8'(i));
    do_stop("R3 R6");
    wait_idle(0, "R3");

    // more than a page: overwrite
    do_ld({9'd9, 7'd10});
    for (int i = 0; i < 130; i++) do_byte(8'(i * 3 + 1));
    do_stop("R4 R6");
    wait_idle(0, "R4");

    // write protect
    wp_pin = 1'b1;
    do_ld({9'd7, 7'd0}); do_byte(8'h99); do_stop("R9");
    repeat (3) @(negedge clk);
    chk(busy == 0, "R9 no busy under protect", busy, 0);
    wp_pin = 1'b0;

    // address only
    do_ld({9'd2, 7'd3}); do_stop("R10");
    repeat (3) @(negedge clk);
    chk(busy == 0, "R10 no busy on empty stop", busy, 0);

    // byte without open transaction
    do_byte(8'h55); do_stop("R11");
    repeat (3) @(negedge clk);
    chk(busy == 0, "R11 no busy after closed byte", busy, 0);

    // simultaneous load and stop: load wins, transaction stays open
    addr_ld = 1'b1; addr_in = {9'd4, 7'd20}; stop_evt = 1'b1;
    m_open = 1; m_page = 9'd4; m_ofs = 7'd20;
    for (int i = 0; i < 128; i++) m_mask[i] = 0;
    @(negedge clk);
    addr_ld = 1'b0; stop_evt = 1'b0;
    chk(busy == 0, "R13 load beats stop", busy, 0);
    do_byte(8'hC3); do_stop("R13 R6");
    wait_idle(0, "R13");

    // inputs ignored during busy
    do_ld({9'd3, 7'd0}); do_byte(8'h11); do_stop("R8 R6");
    do_ld(16'hFF00); do_byte(8'h77); do_stop("R8 during busy");
    wait_idle(3, "R8");
    do_byte(8'h66); do_stop("R8 load ignored");
    repeat (3) @(negedge clk);
    chk(busy == 0, "R8 no transaction opened while busy", busy, 0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule